// File: doc/BRIEF.md
# Lockable Programmable Raster Timing Generator

This block produces the raster timing for a display pipe. A horizontal counter steps once per pixel clock, and a vertical counter steps once per line. Comparing both counters against programmed windows gives a blank signal, CRT horizontal and vertical sync, a separate pair of flat-panel syncs, and a display-active flag. Each timing register packs two 16-bit thresholds, and each threshold is stored as its value minus one. The panel vertical window is normally programmed one line ahead of the CRT vertical window.

Software writes through a simple synchronous register port. Writes only land while the block is unlocked. To unlock it, software writes the unlock code to the key register; any other value written there, zero included, locks it again. Reads always show the stored contents. The timing words pass to the raster only at a frame boundary, or while the generator is stopped, so a mode change never cuts a line short.

Top module: `dispTimingGen`

## Requirements
- R1: While reset is high, and just after it, both counters read 0, blank is 1, every sync output is 0, displayActive is 0, the block is locked and every register reads 0.
- R2: Addresses 1 to 9 only accept writes while the block is unlocked. Address 0 is the key register. Writing UNLOCK_CODE (default 32'h00005A3C) there unlocks the block. Writing any other value, 0 included, locks it. Reading address 0 returns 1 in bit 0 when the block is unlocked.
- R3: A read returns the stored contents combinationally, whether locked or not. The address map is: 1 config, 2 horizontal main, 3 horizontal blank, 4 horizontal sync, 5 panel horizontal sync, 6 vertical main, 7 vertical blank, 8 vertical sync, 9 panel vertical sync. Each timing word carries its first threshold in bits 15:0 and its second in bits 31:16. The main word holds active-1 (low) and total-1 (high). The other words hold start-1 (low) and end-1 (high). The config word uses bit 0 run, bit 1 video enable, bit 2 hsync enable, bit 3 vsync enable, bit 4 panel enable.
- R4: While running, hCount counts 0 up to total-1 and then returns to 0. vCount steps by one each time hCount wraps, and returns to 0 after its own total-1.
- R5: blank is 1 when hCount lies within the inclusive horizontal blank window, when vCount lies within the inclusive vertical blank window, or when run or video enable is 0.
- R6: hSync is 1 exactly when run and hsync enable are set and hCount is within the inclusive horizontal sync window. vSync behaves the same way with vCount and vsync enable.
- R7: panelHSync and panelVSync use the panel sync words and need run and panel enable. panelPower follows panel enable. When the panel vertical word is the CRT value minus one, panel vsync leads CRT vsync by one line.
- R8: displayActive is 1 when run and video enable are set, hCount is at or below active-1, and vCount is at or below active-1.
- R9: A timing word written while running takes effect in the cycle after the last pixel of the last line. While run is 0, it takes effect one cycle after the write.
- R10: When run is 0, both counters are held at 0, blank is 1 and every sync output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous reset, active high |
| regWrEn | input | 1 | register write strobe |
| regAddr | input | 4 | register address |
| regWrData | input | 32 | write data |
| regRdData | output | 32 | read data for regAddr |
| hCount | output | 16 | horizontal position |
| vCount | output | 16 | vertical position |
| blank | output | 1 | blanking |
| hSync | output | 1 | CRT horizontal sync |
| vSync | output | 1 | CRT vertical sync |
| panelHSync | output | 1 | panel horizontal sync |
| panelVSync | output | 1 | panel vertical sync |
| panelPower | output | 1 | panel power and data enable |
| displayActive | output | 1 | visible pixel |

## Verification
The bench rewrites the horizontal main word partway through a frame. A design that applied the new total at once would wrap the line early, and the line count would come out wrong. It writes to the registers while locked and after relocking with zero. A leaky lock would show the new value on readback. It compares the panel and CRT vertical windows line by line. An off-by-one window edge would move a sync pulse by a line or a pixel. It also stops the generator mid-raster, where a missing forced blank or a counter that kept running shows at once.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int FW = 16;
  localparam int NTIM = 8;

  typedef logic [FW-1:0] fld_t;

  typedef struct packed {
    fld_t hi;
    fld_t lo;
  } regPair_t;

  typedef struct packed {
    regPair_t hMain;
    regPair_t hBlank;
    regPair_t hSync;
    regPair_t pHSync;
    regPair_t vMain;
    regPair_t vBlank;
    regPair_t vSync;
    regPair_t pVSync;
  } timingSet_t;

  typedef struct packed {
    logic run;
    logic videoOn;
    logic hSyncOn;
    logic vSyncOn;
    logic panelOn;
  } ctrlStrobe_t;

  typedef enum logic [3:0] {
    A_KEY    = 4'd0,
    A_CFG    = 4'd1,
    A_HMAIN  = 4'd2,
    A_HBLANK = 4'd3,
    A_HSYNC  = 4'd4,
    A_PHSYNC = 4'd5,
    A_VMAIN  = 4'd6,
    A_VBLANK = 4'd7,
    A_VSYNC  = 4'd8,
    A_PVSYNC = 4'd9
  } regAddr_e;

  function automatic logic inWin(fld_t c, regPair_t w);
    return (c >= w.lo) && (c <= w.hi);
  endfunction
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter logic [31:0] UNLOCK_CODE = 32'h0000_5A3C,
  parameter int CFG_W = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output timingSet_t  pending,
  output ctrlStrobe_t strobes
);
  localparam int TBASE = 2;

  logic             unlocked;
  logic [CFG_W-1:0] cfgReg;
  logic [31:0]      tReg [NTIM];
  logic             wrOk;

  assign wrOk = regWrEn && unlocked && (regAddr != A_KEY);

  always_ff @(posedge clk) begin
    if (rst) unlocked <= 1'b0;
    else if (regWrEn && regAddr == A_KEY) unlocked <= (regWrData == UNLOCK_CODE);
  end

  always_ff @(posedge clk) begin
    if (rst) cfgReg <= '0;
    else if (wrOk && regAddr == A_CFG) cfgReg <= regWrData[CFG_W-1:0];
  end

  for (genvar i = 0; i < NTIM; i++) begin : g_tim
    always_ff @(posedge clk) begin
      if (rst) tReg[i] <= '0;
      else if (wrOk && regAddr == 4'(i + TBASE)) tReg[i] <= regWrData;
    end
  end

  assign pending = {tReg[0], tReg[1], tReg[2], tReg[3],
                    tReg[4], tReg[5], tReg[6], tReg[7]};

  assign strobes.run     = cfgReg[0];
  assign strobes.videoOn = cfgReg[1];
  assign strobes.hSyncOn = cfgReg[2];
  assign strobes.vSyncOn = cfgReg[3];
  assign strobes.panelOn = cfgReg[4];

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_KEY:    regRdData = {31'd0, unlocked};
      A_CFG:    regRdData = {{(32-CFG_W){1'b0}}, cfgReg};
      A_HMAIN, A_HBLANK, A_HSYNC, A_PHSYNC,
      A_VMAIN, A_VBLANK, A_VSYNC, A_PVSYNC:
                regRdData = tReg[regAddr - 4'(TBASE)];
      default:  regRdData = '0;
    endcase
  end

  // R2: a locked write leaves every stored register unchanged
  p_locked_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && !unlocked && regAddr != A_KEY) |=> ($stable(cfgReg) && $stable(pending)));

  // R2: writing zero to the key register relocks
  p_relock_r2: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == A_KEY && regWrData == 32'd0) |=> !unlocked);
endmodule

// File: rtl/dtg_raster.sv
module dtg_raster
  import dtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t strobes,
  input  timingSet_t  pending,
  output fld_t        hCount,
  output fld_t        vCount,
  output logic        blank,
  output logic        hSync,
  output logic        vSync,
  output logic        panelHSync,
  output logic        panelVSync,
  output logic        panelPower,
  output logic        displayActive
);
  timingSet_t act;
  logic hWrap, vWrap, frameEnd, shown;

  assign hWrap    = hCount >= act.hMain.hi;
  assign vWrap    = vCount >= act.vMain.hi;
  assign frameEnd = strobes.run && hWrap && vWrap;

  always_ff @(posedge clk) begin
    if (rst) act <= '0;
    else if (!strobes.run || frameEnd) act <= pending;
  end

  always_ff @(posedge clk) begin
    if (rst || !strobes.run) begin
      hCount <= '0;
      vCount <= '0;
    end else if (hWrap) begin
      hCount <= '0;
      vCount <= vWrap ? '0 : vCount + 1'b1;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  assign shown = strobes.run && strobes.videoOn;
  assign blank = !shown || inWin(hCount, act.hBlank) || inWin(vCount, act.vBlank);
  assign hSync = strobes.run && strobes.hSyncOn && inWin(hCount, act.hSync);
  assign vSync = strobes.run && strobes.vSyncOn && inWin(vCount, act.vSync);
  assign panelHSync = strobes.run && strobes.panelOn && inWin(hCount, act.pHSync);
  assign panelVSync = strobes.run && strobes.panelOn && inWin(vCount, act.pVSync);
  assign panelPower = strobes.panelOn;
  assign displayActive = shown && (hCount <= act.hMain.lo) && (vCount <= act.vMain.lo);

  // R4: the horizontal counter never passes the active total
  p_hcount_bound_r4: assert property (@(posedge clk) disable iff (rst)
    strobes.run |-> (hCount <= act.hMain.hi));

  // R4: a nonzero position is always one past the previous one
  p_hcount_step_r4: assert property (@(posedge clk) disable iff (rst)
    (strobes.run && hCount != '0) |-> (hCount == fld_t'($past(hCount) + 1'b1)));

  // R9: active timing only changes at a frame boundary while running
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (strobes.run && $past(strobes.run) && !$past(frameEnd)) |-> $stable(act));

  // R10: a stopped generator is blank with all syncs low
  p_stopped_r10: assert property (@(posedge clk) disable iff (rst)
    !strobes.run |-> (blank && !hSync && !vSync && !panelHSync && !panelVSync));
endmodule

// File: rtl/dispTimingGen.sv
module dispTimingGen
  import dtg_pkg::*;
#(
  parameter logic [31:0] UNLOCK_CODE = 32'h0000_5A3C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic [15:0] hCount,
  output logic [15:0] vCount,
  output logic        blank,
  output logic        hSync,
  output logic        vSync,
  output logic        panelHSync,
  output logic        panelVSync,
  output logic        panelPower,
  output logic        displayActive
);
  timingSet_t  pending;
  ctrlStrobe_t strobes;

  dtg_regs #(.UNLOCK_CODE(UNLOCK_CODE)) u_regs (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .pending(pending), .strobes(strobes)
  );

  dtg_raster u_raster (
    .clk(clk), .rst(rst), .strobes(strobes), .pending(pending),
    .hCount(hCount), .vCount(vCount), .blank(blank), .hSync(hSync),
    .vSync(vSync), .panelHSync(panelHSync), .panelVSync(panelVSync),
    .panelPower(panelPower), .displayActive(displayActive)
  );
endmodule

// File: tb/dispTimingGen_tb.sv
module dispTimingGen_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h0000_5A3C;

  logic clk = 0, rst = 1, regWrEn = 0;
  logic [3:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic [15:0] hCount, vCount;
  logic blank, hSync, vSync, panelHSync, panelVSync, panelPower, displayActive;

  int nRun = 0, nFail = 0;
  bit done = 0;

  dispTimingGen #(.UNLOCK_CODE(KEY)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [15:0] h, v;
    logic bl, hs, vs, phs, pvs, pp, da;
  } exp_t;
  exp_t q[$];

  // reference model built from the requirements
  logic mUnl;
  logic [4:0] mCfg;
  logic [31:0] mPend [8];
  logic [31:0] mAct [8];
  logic [15:0] mH, mV;

  function automatic logic win(logic [15:0] c, logic [31:0] w);
    return (c >= w[15:0]) && (c <= w[31:16]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mUnl = 0; mCfg = 0; mH = 0; mV = 0;
      for (int i = 0; i < 8; i++) begin mPend[i] = 0; mAct[i] = 0; end
    end else begin
      logic run, hw, vw, fe;
      run = mCfg[0];
      hw = mH >= mAct[0][31:16];
      vw = mV >= mAct[4][31:16];
      fe = run && hw && vw;
      if (!run || fe) for (int i = 0; i < 8; i++) mAct[i] = mPend[i];
      if (!run) begin mH = 0; mV = 0; end
      else if (hw) begin mH = 0; mV = vw ? 16'd0 : mV + 16'd1; end
      else mH = mH + 16'd1;
      if (regWrEn) begin
        if (regAddr == 0) mUnl = (regWrData == KEY);
        else if (mUnl && regAddr == 1) mCfg = regWrData[4:0];
        else if (mUnl && regAddr >= 2 && regAddr <= 9) mPend[regAddr-2] = regWrData;
      end
    end
  end

  // predictor: push expected outputs for this cycle
  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      logic run, shown;
      run = mCfg[0];
      shown = run && mCfg[1];
      e.h = mH; e.v = mV;
      e.bl = !shown || win(mH, mAct[1]) || win(mV, mAct[5]);
      e.hs = run && mCfg[2] && win(mH, mAct[2]);
      e.vs = run && mCfg[3] && win(mV, mAct[6]);
      e.phs = run && mCfg[4] && win(mH, mAct[3]);
      e.pvs = run && mCfg[4] && win(mV, mAct[7]);
      e.pp = mCfg[4];
      e.da = shown && mH <= mAct[0][15:0] && mV <= mAct[4][15:0];
      q.push_back(e);
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R4", "hCount", hCount, e.h);
      chk("R4", "vCount", vCount, e.v);
      chk("R5", "blank", blank, e.bl);
      chk("R6", "hSync", hSync, e.hs);
      chk("R6", "vSync", vSync, e.vs);
      chk("R7", "panelHSync", panelHSync, e.phs);
      chk("R7", "panelVSync", panelVSync, e.pvs);
      chk("R7", "panelPower", panelPower, e.pp);
      chk("R8", "displayActive", displayActive, e.da);
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdChk(string req, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #2;
    chk(req, "regRdData", regRdData, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "hCount", hCount, 0);
    chk("R1", "vCount", vCount, 0);
    chk("R1", "blank", blank, 1);
    chk("R1", "syncs", {hSync, vSync, panelHSync, panelVSync, displayActive}, 0);
    @(negedge clk); rst = 0;
    rdChk("R1", 0, 0);
    rdChk("R1", 2, 0);

    // R2 locked writes dropped
    wr(2, 32'h000E_0007);
    rdChk("R2", 2, 0);
    wr(1, 32'h1F);
    rdChk("R2", 1, 0);
    wr(0, 32'h1234);
    rdChk("R2", 0, 0);
    wr(0, KEY);
    rdChk("R2", 0, 1);

    // program 8x4 active in 15x8 total
    wr(2, 32'h000E_0007);
    wr(3, 32'h000E_0007);
    wr(4, 32'h000C_0009);
    wr(5, 32'h000C_0009);
    wr(6, 32'h0007_0003);
    wr(7, 32'h0007_0003);
    wr(8, 32'h0006_0004);
    wr(9, 32'h0005_0003);
    rdChk("R3", 4, 32'h000C_0009);
    rdChk("R3", 9, 32'h0005_0003);

    // R2 relock with zero, write ignored, R3 readback still works
    wr(0, 0);
    rdChk("R2", 0, 0);
    wr(4, 32'h0003_0001);
    rdChk("R2", 4, 32'h000C_0009);
    rdChk("R3", 8, 32'h0006_0004);

    wr(0, KEY);
    wr(1, 32'h1F);
    rdChk("R3", 1, 32'h1F);
    repeat (250) @(negedge clk);

    // R7 panel vsync leads CRT vsync by a line
    while (!(vCount == 3 && hCount == 0)) @(negedge clk);
    #2;
    chk("R7", "panelVSync line3", panelVSync, 1);
    chk("R7", "vSync line3", vSync, 0);

    // R9 mid-frame change of horizontal total waits for frame end
    while (!(vCount == 1 && hCount == 0)) @(negedge clk);
    regWrEn = 1; regAddr = 2; regWrData = 32'h000A_0005;
    @(negedge clk); regWrEn = 0;
    repeat (12) @(negedge clk);
    #2;
    chk("R9", "old total kept", hCount, 13);
    repeat (300) @(negedge clk);

    // panel off
    wr(1, 32'h0F);
    repeat (100) @(negedge clk);
    // video off
    wr(1, 32'h1D);
    repeat (100) @(negedge clk);

    // R10 stop mid-raster
    while (hCount != 4) @(negedge clk);
    regWrEn = 1; regAddr = 1; regWrData = 32'h1E;
    @(negedge clk); regWrEn = 0;
    @(negedge clk);
    #2;
    chk("R10", "hCount", hCount, 0);
    chk("R10", "vCount", vCount, 0);
    chk("R10", "blank", blank, 1);
    chk("R10", "syncs", {hSync, vSync, panelHSync, panelVSync}, 0);

    // R9 while stopped a write applies at once, then restart
    wr(2, 32'h0009_0004);
    wr(1, 32'h1F);
    repeat (200) @(negedge clk);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule